// File: doc/BRIEF.md
# PCM Long-Sync Master Serial Port

This block is the master side of a serial PCM audio link. It runs entirely from the system clock. From that clock it generates the bit clock and a long frame sync, and it exchanges one 16-bit sample in each direction per frame. Transmit samples arrive on a ready/valid port. The block offers `txReady` for one cycle at the start of every frame. It sends the sample bit by bit on rising bit-clock edges. When no sample is offered, it sends silence and flags an underrun.

Receive bits are sampled on falling bit-clock edges. After the sixteenth bit, the block presents the assembled word with a one-cycle valid pulse. The data output comes with an output-enable for a tri-state pad. The enable covers the sixteen data bits and drops in the middle of the last one, so the line is released for the rest of the frame.

The bit rate is chosen by a small select input. The divisor is derived from the system clock frequency parameter. A new rate takes effect only at a frame boundary.

Top module: `pcm_lfs_master`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `pcmBclk`, `pcmSync`, `pcmTxOe`, `pcmTxd`, `rxValid`, `txReady` and `underrun` all low.
- R2: `pcmBclk` has a 50 percent duty cycle. Each high phase and each low phase lasts H system cycles, where H = floor(SYS_CLK_HZ / (2 * 128000 * 2^s)). Here s is `rateSel`, and values of `rateSel` above 4 act as 4. This gives bit rates from 128 kHz to 2048 kHz.
- R3: The first bit-clock rise after reset starts frame bit 0. Frames repeat every FRAME_BITS bit periods. `pcmSync` rises with the bit-clock rise that starts bit 0 and falls with the rise that starts bit 2, so it is high for exactly bits 0 and 1.
- R4: Frame bits 0 to 15 carry the accepted transmit word most significant bit first: frame bit k is `txData[15-k]`. `pcmTxd` changes only together with a rising bit-clock edge.
- R5: `pcmTxOe` rises with the bit-clock rise that starts bit 0 and falls with the bit-clock fall inside bit 15. It stays low during the idle bits 16 to FRAME_BITS-1.
- R6: `pcmRxd` is sampled on each falling bit-clock edge of bits 0 to 15. The bit sampled in frame bit k becomes `rxWord[15-k]`.
- R7: `rxValid` is a single-cycle pulse. It appears in the cycle in which the bit clock falls inside bit 15, once per frame, and `rxWord` is valid with it.
- R8: `txReady` is high for exactly one cycle per frame, in the cycle just before the rise that starts bit 0. The word on `txData` is taken if `txValid` is high in that cycle.
- R9: If `txValid` is low while `txReady` is high, the frame sends sixteen zero bits. In that case `underrun` is high from the start of the frame until the next frame start; otherwise it is low for the frame.
- R10: `rateSel` is captured during reset and at every frame start. A change in the middle of a frame leaves that frame's bit period unchanged and applies from the next bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Bit rate select: 128 kHz shifted left by the value, capped at 4 |
| txData | input | 16 | Transmit sample |
| txValid | input | 1 | Transmit sample valid |
| txReady | output | 1 | One-cycle accept strobe at frame start |
| rxWord | output | 16 | Last received sample |
| rxValid | output | 1 | One-cycle pulse when rxWord is updated |
| underrun | output | 1 | Current frame carries silence because no sample was offered |
| pcmBclk | output | 1 | Generated bit clock |
| pcmSync | output | 1 | Long frame sync |
| pcmTxd | output | 1 | Serial data out |
| pcmTxOe | output | 1 | Output enable for the tri-state data pad |
| pcmRxd | input | 1 | Serial data in |

## Verification
The hardest situation to produce from the ports is a rate change that lands exactly on the frame boundary. In that case one bit period must still use the old divisor while the next one uses the new divisor. The stimulus changes `rateSel` a few cycles after each accept strobe, so the change falls inside a frame. It steps through a slow rate, a fast rate and an out-of-range select. The monitor measures every bit period against the divisor in force at the preceding frame start. An underrun frame is placed between two valid samples, so the zero word and the flag are checked against their neighbours.

// File: rtl/pcm_lfs_pkg.sv
package pcm_lfs_pkg;

  localparam int DATA_BITS = 16;

  // strobes from the sequencer to the datapath, all one system cycle wide
  typedef struct packed {
    logic loadWord;    // rise that starts bit 0
    logic shiftOut;    // rise that starts bits 1..15
    logic sampleIn;    // fall inside bits 0..15
    logic lastSample;  // fall inside bit 15
  } pcmStrobes_t;

endpackage

// File: rtl/pcm_lfs_ctrl.sv
module pcm_lfs_ctrl
  import pcm_lfs_pkg::*;
#(
  parameter int SYS_CLK_HZ = 125_000_000,
  parameter int FRAME_BITS = 18,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  output logic             bclkOut,
  output logic             syncOut,
  output logic             oeOut,
  output pcmStrobes_t      strobes
);

  localparam int BASE_HZ   = 128_000;
  localparam int MAX_SHIFT = 4;
  localparam int MAX_HALF  = SYS_CLK_HZ / (2 * BASE_HZ);
  localparam int CNT_W     = $clog2(MAX_HALF + 1);
  localparam int BIT_W     = $clog2(FRAME_BITS + 1);
  localparam int NUM_SEL   = 2 ** SEL_W;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(DATA_BITS - 1);

  // half-period table indexed by the select value; high selects saturate
  logic [CNT_W-1:0] halfTable [NUM_SEL];
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_rate
    if (g <= MAX_SHIFT) begin : g_valid
      assign halfTable[g] = CNT_W'(SYS_CLK_HZ / (2 * (BASE_HZ << g)));
    end else begin : g_cap
      assign halfTable[g] = CNT_W'(SYS_CLK_HZ / (2 * (BASE_HZ << MAX_SHIFT)));
    end
  end

  logic [CNT_W-1:0] halfReg;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bclkR;
  logic             syncR;
  logic             oeR;

  logic tick;
  logic riseTick;
  logic fallTick;
  logic frameEnd;
  logic inData;

  assign tick     = (halfCnt == halfReg - 1'b1);
  assign riseTick = tick && !bclkR;
  assign fallTick = tick && bclkR;
  assign frameEnd = (bitCnt == LAST_BIT);
  assign inData   = (bitCnt <= LAST_DATA);

  assign strobes.loadWord   = riseTick && frameEnd;
  assign strobes.shiftOut   = riseTick && !frameEnd && (bitCnt < LAST_DATA);
  assign strobes.sampleIn   = fallTick && inData;
  assign strobes.lastSample = fallTick && (bitCnt == LAST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      halfReg <= halfTable[rateSel];
      halfCnt <= '0;
      bclkR   <= 1'b0;
      bitCnt  <= LAST_BIT;
      syncR   <= 1'b0;
      oeR     <= 1'b0;
    end else begin
      halfCnt <= tick ? '0 : halfCnt + 1'b1;
      if (tick) begin
        bclkR <= !bclkR;
      end
      if (riseTick) begin
        bitCnt <= frameEnd ? '0 : bitCnt + 1'b1;
        // high for the rises that start bit 0 and bit 1
        syncR  <= frameEnd || (bitCnt == '0);
        if (frameEnd) begin
          oeR     <= 1'b1;
          halfReg <= halfTable[rateSel];
        end
      end
      if (strobes.lastSample) begin
        oeR <= 1'b0;
      end
    end
  end

  assign bclkOut = bclkR;
  assign syncOut = syncR;
  assign oeOut   = oeR;

endmodule

// File: rtl/pcm_lfs_dp.sv
module pcm_lfs_dp
  import pcm_lfs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  pcmStrobes_t          strobes,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 txValid,
  input  logic                 rxd,
  output logic                 txd,
  output logic [DATA_BITS-1:0] rxWord,
  output logic                 rxValid,
  output logic                 underrun
);

  logic [DATA_BITS-1:0] txShift;
  logic [DATA_BITS-1:0] rxShift;
  logic [DATA_BITS-1:0] nextWord;
  logic [DATA_BITS-1:0] rxAssembled;

  assign nextWord    = txValid ? txData : '0;
  assign rxAssembled = {rxShift[DATA_BITS-2:0], rxd};

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift  <= '0;
      txd      <= 1'b0;
      underrun <= 1'b0;
      rxShift  <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobes.loadWord) begin
        txd      <= nextWord[DATA_BITS-1];
        txShift  <= {nextWord[DATA_BITS-2:0], 1'b0};
        underrun <= !txValid;
      end else if (strobes.shiftOut) begin
        txd     <= txShift[DATA_BITS-1];
        txShift <= {txShift[DATA_BITS-2:0], 1'b0};
      end
      if (strobes.sampleIn) begin
        rxShift <= rxAssembled;
      end
      if (strobes.lastSample) begin
        rxWord  <= rxAssembled;
        rxValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_lfs_master.sv
module pcm_lfs_master
  import pcm_lfs_pkg::*;
#(
  parameter int SYS_CLK_HZ = 125_000_000,
  parameter int FRAME_BITS = 18
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  rateSel,
  input  logic [15:0] txData,
  input  logic        txValid,
  output logic        txReady,
  output logic [15:0] rxWord,
  output logic        rxValid,
  output logic        underrun,
  output logic        pcmBclk,
  output logic        pcmSync,
  output logic        pcmTxd,
  output logic        pcmTxOe,
  input  logic        pcmRxd
);

  pcmStrobes_t strobes;

  pcm_lfs_ctrl #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .FRAME_BITS(FRAME_BITS),
    .SEL_W     (3)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rateSel(rateSel),
    .bclkOut(pcmBclk),
    .syncOut(pcmSync),
    .oeOut  (pcmTxOe),
    .strobes(strobes)
  );

  pcm_lfs_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .txData  (txData),
    .txValid (txValid),
    .rxd     (pcmRxd),
    .txd     (pcmTxd),
    .rxWord  (rxWord),
    .rxValid (rxValid),
    .underrun(underrun)
  );

  assign txReady = strobes.loadWord;

endmodule

// File: rtl/pcm_lfs_master_chk.sv
module pcm_lfs_master_chk (
  input logic clk,
  input logic rst,
  input logic pcmBclk,
  input logic pcmSync,
  input logic pcmTxOe,
  input logic pcmTxd,
  input logic rxValid,
  input logic txReady
);

  AST_SYNC_RISE_ON_BCLK: assert property (@(posedge clk) disable iff (rst) $rose(pcmSync) |-> $rose(pcmBclk)); // R3
  AST_SYNC_FALL_ON_BCLK: assert property (@(posedge clk) disable iff (rst) $fell(pcmSync) |-> $rose(pcmBclk)); // R3
  AST_TXD_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (rst) !$stable(pcmTxd) |-> $rose(pcmBclk)); // R4
  AST_SYNC_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst) pcmSync |-> pcmTxOe); // R5
  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (rst) $fell(pcmTxOe) |-> $fell(pcmBclk)); // R5
  AST_RXVALID_SINGLE: assert property (@(posedge clk) disable iff (rst) rxValid |=> !rxValid); // R7
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst) txReady |=> !txReady); // R8

endmodule

bind pcm_lfs_master pcm_lfs_master_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pcmBclk(pcmBclk),
  .pcmSync(pcmSync),
  .pcmTxOe(pcmTxOe),
  .pcmTxd (pcmTxd),
  .rxValid(rxValid),
  .txReady(txReady)
);

// File: tb/pcm_lfs_master_bench.sv
module pcm_lfs_master_bench;

  localparam int SYS_HZ = 8_192_000;
  localparam int FB     = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rateSel = 3'd4;
  logic [15:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [15:0] rxWord;
  logic        rxValid;
  logic        underrun;
  logic        pcmBclk;
  logic        pcmSync;
  logic        pcmTxd;
  logic        pcmTxOe;
  logic        pcmRxd = 1'b0;

  always #4 clk = ~clk;

  pcm_lfs_master #(.SYS_CLK_HZ(SYS_HZ), .FRAME_BITS(FB)) u_pcm_lfs_master (
    .clk(clk), .rst(rst), .rateSel(rateSel), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxWord(rxWord), .rxValid(rxValid), .underrun(underrun),
    .pcmBclk(pcmBclk), .pcmSync(pcmSync), .pcmTxd(pcmTxd), .pcmTxOe(pcmTxOe),
    .pcmRxd(pcmRxd)
  );

  int checks = 0;
  int fails  = 0;
  int rxSeen = 0;
  bit finished = 0;

  typedef struct { logic [15:0] w; bit under; } txExp_t;
  txExp_t      txQ[$];
  logic [15:0] rxQ[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int halfOf(int s);
    int c = (s > 4) ? 4 : s;
    return SYS_HZ / (2 * (128000 << c));
  endfunction

  // driver: offers one word per frame and records what the line must carry
  task automatic send(logic [15:0] w, bit valid);
    txData  = w;
    txValid = valid;
    do @(negedge clk); while (!txReady);
    txQ.push_back('{valid ? w : 16'h0, !valid});
    @(posedge clk);
    #1 txValid = 1'b0;
  endtask

  task automatic setRate(logic [2:0] s);
    repeat (10) @(negedge clk);
    rateSel = s;
  endtask

  // monitor state
  bit          pB = 0, pS = 0, pV = 0, pR = 0, inFrame = 0;
  int          benchBit = 0, cyc = 0, lastRise = -1, activeHalf = 0, frameNo = 0;
  logic [15:0] txAcc = '0, rxCur = '0;
  txExp_t      curTx;

  always @(negedge clk) begin
    if (!rst) begin
      bit rise, fall;
      cyc++;
      rise = pcmBclk && !pB;
      fall = !pcmBclk && pB;
      if (rise) begin
        benchBit = inFrame ? (benchBit + 1) % FB : 0;
        inFrame = 1;
        if (lastRise >= 0)
          check((cyc - lastRise) == 2 * activeHalf, "R2/R10", "bit period", cyc - lastRise, 2 * activeHalf);
        lastRise = cyc;
        check(pcmSync == (benchBit < 2), "R3", "sync level", pcmSync, benchBit < 2);
        check(pcmTxOe == (benchBit < 16), "R5", "output enable", pcmTxOe, benchBit < 16);
        if (benchBit == 0) begin
          activeHalf = halfOf(int'(rateSel));
          if (txQ.size() > 0) curTx = txQ.pop_front();
          else curTx = '{16'h0, 1'b1};
          check(underrun == curTx.under, "R9", "underrun flag", underrun, curTx.under);
          txAcc = '0;
          rxCur = 16'hA5C3 ^ 16'(frameNo * 16'h1357);
          frameNo++;
          rxQ.push_back(rxCur);
        end
        if (benchBit < 16) begin
          txAcc = {txAcc[14:0], pcmTxd};
          pcmRxd = rxCur[15 - benchBit];
          if (benchBit == 15)
            check(txAcc == curTx.w, "R4/R8/R9", "serial word", txAcc, curTx.w);
        end
      end
      if (fall && benchBit == 15)
        check(!pcmTxOe, "R5", "release in bit 15", pcmTxOe, 0);
      if (rxValid || (fall && benchBit == 15)) begin
        check(rxValid == (fall && benchBit == 15), "R7", "valid timing", rxValid, 1);
        check(!pV, "R7", "valid width", pV, 0);
      end
      if (rxValid) begin
        logic [15:0] e;
        e = (rxQ.size() > 0) ? rxQ.pop_front() : 16'hxxxx;
        rxSeen++;
        check(rxWord === e, "R6", "received word", rxWord, e);
      end
      if (txReady) check(!pR, "R8", "ready width", pR, 0);
      pB = pcmBclk; pS = pcmSync; pV = rxValid; pR = txReady;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!pcmBclk && !pcmSync && !pcmTxOe && !pcmTxd, "R1", "serial pins in reset",
          {pcmBclk, pcmSync, pcmTxOe, pcmTxd}, 0);
    check(!rxValid && !txReady && !underrun, "R1", "parallel flags in reset",
          {rxValid, txReady, underrun}, 0);
    rst = 1'b0;
    send(16'hC3A5, 1);
    send(16'h8001, 1);
    setRate(3'd2);
    send(16'h7FFE, 1);
    send(16'h1234, 0);
    setRate(3'd7);
    send(16'h5A5A, 1);
    setRate(3'd0);
    send(16'hFFFF, 1);
    send(16'h0F0F, 1);
    repeat (3000) @(posedge clk);
    check(rxSeen >= 7, "R7", "received frame count", rxSeen, 7);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule